// File: doc/BRIEF.md
# Partitioned Fully Associative Translation Buffer

This block holds up to 64 address translations and searches all of them in parallel. Every slot keeps a virtual page, the partition and context it belongs to, a real-mode flag, a page-size code, the physical page, and four attribute bits: locked, privileged, writable and side-effect. One command is accepted per clock, selected by `op_code`. The commands are lookup, insert, demap by page, demap by context, demap of a whole partition, and diagnostic reads of a slot's tag word or data word.

Lookups and diagnostic reads answer one cycle later on the registered `rsp_*` outputs. Inserts and demaps take effect in the cycle after they are issued. An insert either names its slot or lets the block pick a victim. Victim selection uses per-slot used bits, and locked slots are never chosen while an unlocked one exists.

Top module: `ptlb_top`

## Requirements
- R1: The slot count `N` must lie in 2..64, or elaboration fails. The page-size code is 2 bits wide. Code s selects a page of 2^(13+3s) bytes: 8 KiB, 64 KiB, 512 KiB or 4 MiB.
- R2: A lookup (op_code 0) hits a valid slot when all of these hold: the partition matches, the real flag matches, the virtual address matches above that slot's page offset, and, for non-real slots only, the context matches. In the cycle after the command, `rsp_valid` is 1, `rsp_hit` reports the hit, `rsp_slot` gives the slot, and `rsp_pa` is the slot's physical page with the request's page offset merged in.
- R3: An insert (op_code 1) first aligns the virtual and physical addresses down to the new page size. It then invalidates every valid slot with the same partition and real flag whose page overlaps the new page, whatever that slot's context.
- R4: An insert with `ins_fixed`=1 writes exactly slot `op_slot`.
- R5: An insert with `ins_fixed`=0 scans slots starting just after the last automatically replaced slot, wrapping around. It takes the first slot that is unlocked and not used. Failing that, it takes the first unlocked slot. If every slot is locked, it takes slot N-1. After reset the scan starts at slot 0.
- R6: An insert sets the written slot's used bit. A lookup that hits with `op_upd_used`=1 sets the hit slot's used bit; with `op_upd_used`=0 it leaves the bit alone. If the count of used slots would reach N, the used bits of all unlocked slots are cleared instead.
- R7: Demap-page (op_code 2) invalidates the slot that a lookup with the same inputs would hit, and clears its used bit.
- R8: Demap-context (op_code 3) invalidates every valid non-real slot whose context and partition both match. Real slots and slots of other partitions stay valid.
- R9: Demap-all (op_code 4) invalidates every valid, unlocked slot of the given partition. Locked slots stay valid.
- R10: A tag read (op_code 5) of slot `op_slot` returns all ones if the slot is invalid. For a valid slot the word holds: the partition at bit 61 upward, the inverted size code at bits 57:56, the virtual page bits at bits VA_W-1:13, and the context at bit 0 upward. All other bits are zero.
- R11: A data read (op_code 6) returns all ones for an invalid slot. For a valid slot the word holds: bit 63 = 1, bit 62 locked, bit 61 privileged, bit 60 writable, bit 59 side-effect, bit 58 real, bits 57:56 the size code, and the physical page address at bits PA_W-1:0.
- R12: After reset every slot is invalid and unused, and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | A command is present this cycle |
| op_code | input | 3 | Command selector (0..6) |
| op_va | input | VA_W | Virtual address of the command |
| op_part | input | PART_W | Partition id |
| op_ctx | input | CTX_W | Context id |
| op_real | input | 1 | Real-mode translation flag |
| op_upd_used | input | 1 | A lookup hit sets the used bit |
| op_slot | input | IDX_W | Slot for a fixed insert or a diagnostic read |
| ins_fixed | input | 1 | The insert uses `op_slot` instead of a victim |
| ins_size | input | 2 | Page-size code of the new entry |
| ins_pa | input | PA_W | Physical address of the new entry |
| ins_lock | input | 1 | New entry is locked |
| ins_priv | input | 1 | New entry is privileged |
| ins_wr | input | 1 | New entry is writable |
| ins_se | input | 1 | New entry has side effects |
| rsp_valid | output | 1 | Lookup or read result present |
| rsp_hit | output | 1 | Last lookup hit |
| rsp_slot | output | IDX_W | Slot that hit |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_priv | output | 1 | Privileged attribute of the hit slot |
| rsp_wr | output | 1 | Writable attribute of the hit slot |
| rsp_se | output | 1 | Side-effect attribute of the hit slot |
| rsp_diag | output | 64 | Tag or data word of a diagnostic read |

## Verification
The hardest state to reach from the ports is the point where the used count saturates. All unlocked used bits clear at once, and the next victim then depends on which used bits were set again afterwards. The bench gets there by reset, two locked fixed inserts, and fourteen automatic inserts, which fill the table and trigger the clear. It then sets a single used bit with an updating lookup, and checks that the next automatic insert skips that slot. A second run locks every slot, to show that the fallback overwrites slot N-1.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
    localparam int BASE_SHIFT = 13;
    localparam int SHIFT_STEP = 3;
    localparam int SIZE_W     = 2;

    typedef enum logic [2:0] {
        OP_LOOKUP    = 3'd0,
        OP_INSERT    = 3'd1,
        OP_DMAP_PAGE = 3'd2,
        OP_DMAP_CTX  = 3'd3,
        OP_DMAP_ALL  = 3'd4,
        OP_RD_TAG    = 3'd5,
        OP_RD_DATA   = 3'd6,
        OP_IDLE      = 3'd7
    } tlb_op_e;

    // Mask of the page-offset bits for a size code
    function automatic logic [63:0] off_mask64(input logic [SIZE_W-1:0] s);
        return (64'd1 << (BASE_SHIFT + SHIFT_STEP * int'(s))) - 64'd1;
    endfunction
endpackage

// File: rtl/ptlb_match.sv
module ptlb_match
    import ptlb_pkg::*;
#(
    parameter int N      = 16,
    parameter int VA_W   = 32,
    parameter int CTX_W  = 13,
    parameter int PART_W = 3
) (
    input  logic [N-1:0]                    e_valid,
    input  logic [N-1:0]                    e_real,
    input  logic [N-1:0]                    e_lock,
    input  logic [N-1:0][VA_W-1:0]          e_va,
    input  logic [N-1:0][CTX_W-1:0]         e_ctx,
    input  logic [N-1:0][PART_W-1:0]        e_part,
    input  logic [N-1:0][SIZE_W-1:0]        e_size,
    input  logic [VA_W-1:0]                 q_va,
    input  logic [PART_W-1:0]               q_part,
    input  logic [CTX_W-1:0]                q_ctx,
    input  logic                            q_real,
    input  logic [SIZE_W-1:0]               q_size,
    output logic [N-1:0]                    hit_vec,
    output logic [N-1:0]                    ovl_vec,
    output logic [N-1:0]                    ctx_vec,
    output logic [N-1:0]                    all_vec
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic [VA_W-1:0]   own_m;
        logic [VA_W-1:0]   big_m;
        logic [SIZE_W-1:0] big_s;
        logic              same_pr;
        logic              part_eq;

        assign big_s   = (e_size[i] > q_size) ? e_size[i] : q_size;
        assign own_m   = ~VA_W'(off_mask64(e_size[i]));
        assign big_m   = ~VA_W'(off_mask64(big_s));
        assign part_eq = (e_part[i] == q_part);
        assign same_pr = e_valid[i] && part_eq && (e_real[i] == q_real);

        assign hit_vec[i] = same_pr && (((e_va[i] ^ q_va) & own_m) == '0)
                            && (q_real || (e_ctx[i] == q_ctx));
        assign ovl_vec[i] = same_pr && (((e_va[i] ^ q_va) & big_m) == '0);
        assign ctx_vec[i] = e_valid[i] && !e_real[i] && part_eq && (e_ctx[i] == q_ctx);
        assign all_vec[i] = e_valid[i] && !e_lock[i] && part_eq;
    end
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     lock_vec,
    input  logic [N-1:0]     used_vec,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] victim
);
    logic             got_free, got_any;
    logic [IDX_W-1:0] pick_free, pick_any;

    always_comb begin
        got_free  = 1'b0;
        got_any   = 1'b0;
        pick_free = '0;
        pick_any  = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (!lock_vec[j]) begin
                if (!got_any) begin
                    got_any  = 1'b1;
                    pick_any = IDX_W'(j);
                end
                if (!used_vec[j] && !got_free) begin
                    got_free  = 1'b1;
                    pick_free = IDX_W'(j);
                end
            end
        end
        victim = got_free ? pick_free : (got_any ? pick_any : IDX_W'(N - 1));
    end
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
    import ptlb_pkg::*;
#(
    parameter int N      = 16,
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int CTX_W  = 13,
    parameter int PART_W = 3,
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [VA_W-1:0]   op_va,
    input  logic [PART_W-1:0] op_part,
    input  logic [CTX_W-1:0]  op_ctx,
    input  logic              op_real,
    input  logic              op_upd_used,
    input  logic [IDX_W-1:0]  op_slot,
    input  logic              ins_fixed,
    input  logic [1:0]        ins_size,
    input  logic [PA_W-1:0]   ins_pa,
    input  logic              ins_lock,
    input  logic              ins_priv,
    input  logic              ins_wr,
    input  logic              ins_se,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_slot,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_priv,
    output logic              rsp_wr,
    output logic              rsp_se,
    output logic [63:0]       rsp_diag
);
    // R1: legal slot count and field widths
    if (N < 2 || N > 64) begin : g_bad_count
        $error("ptlb_top: N must lie in 2..64");
    end
    if (VA_W > 56 || PA_W > 56 || CTX_W > BASE_SHIFT || PART_W > 3
        || VA_W <= BASE_SHIFT + SHIFT_STEP * 3) begin : g_bad_width
        $error("ptlb_top: field widths do not fit the diagnostic words");
    end

    typedef struct packed {
        logic [N-1:0]              valid;
        logic [N-1:0]              used;
        logic [N-1:0]              lock;
        logic [N-1:0]              priv;
        logic [N-1:0]              wr;
        logic [N-1:0]              se;
        logic [N-1:0]              rl;
        logic [N-1:0][VA_W-1:0]    va;
        logic [N-1:0][PA_W-1:0]    pa;
        logic [N-1:0][CTX_W-1:0]   ctx;
        logic [N-1:0][PART_W-1:0]  part;
        logic [N-1:0][SIZE_W-1:0]  size;
        logic [IDX_W-1:0]          ptr;
        logic [CNT_W-1:0]          cnt;
        logic                      rsp_valid;
        logic                      rsp_hit;
        logic [IDX_W-1:0]          rsp_slot;
        logic [PA_W-1:0]           rsp_pa;
        logic                      rsp_priv;
        logic                      rsp_wr;
        logic                      rsp_se;
        logic [63:0]               rsp_diag;
    } st_t;

    st_t st_q, st_d;

    tlb_op_e          op;
    logic [VA_W-1:0]  q_va;
    logic [N-1:0]     hit_vec, ovl_vec, ctx_vec, all_vec, clr;
    logic [IDX_W-1:0] victim, hit_idx, wslot;
    logic             any_hit;
    logic [63:0]      tag_w, data_w;

    assign op   = tlb_op_e'(op_code);
    assign q_va = (op == OP_INSERT) ? (op_va & ~VA_W'(off_mask64(ins_size))) : op_va;

    ptlb_match #(.N(N), .VA_W(VA_W), .CTX_W(CTX_W), .PART_W(PART_W)) u_match (
        .e_valid(st_q.valid), .e_real(st_q.rl), .e_lock(st_q.lock),
        .e_va(st_q.va), .e_ctx(st_q.ctx), .e_part(st_q.part), .e_size(st_q.size),
        .q_va(q_va), .q_part(op_part), .q_ctx(op_ctx), .q_real(op_real),
        .q_size(ins_size),
        .hit_vec(hit_vec), .ovl_vec(ovl_vec), .ctx_vec(ctx_vec), .all_vec(all_vec)
    );

    ptlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
        .lock_vec(st_q.lock), .used_vec(st_q.used), .ptr(st_q.ptr), .victim(victim)
    );

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end
    assign any_hit = |hit_vec;
    assign wslot   = ins_fixed ? op_slot : victim;

    // Diagnostic words of slot op_slot
    always_comb begin
        tag_w  = '0;
        data_w = '0;
        tag_w[61 +: PART_W]        = st_q.part[op_slot];
        tag_w[57:56]               = ~st_q.size[op_slot];
        tag_w[VA_W-1:BASE_SHIFT]   = st_q.va[op_slot][VA_W-1:BASE_SHIFT];
        tag_w[CTX_W-1:0]           = st_q.ctx[op_slot];
        data_w[63]                 = 1'b1;
        data_w[62]                 = st_q.lock[op_slot];
        data_w[61]                 = st_q.priv[op_slot];
        data_w[60]                 = st_q.wr[op_slot];
        data_w[59]                 = st_q.se[op_slot];
        data_w[58]                 = st_q.rl[op_slot];
        data_w[57:56]              = st_q.size[op_slot];
        data_w[PA_W-1:0]           = st_q.pa[op_slot];
        if (!st_q.valid[op_slot]) begin
            tag_w  = '1;
            data_w = '1;
        end
    end

    always_comb begin
        logic [PA_W-1:0] pmask;
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        clr            = '0;
        pmask          = PA_W'(off_mask64(st_q.size[hit_idx]));
        if (op_valid) begin
            case (op)
                OP_LOOKUP: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_hit   = any_hit;
                    st_d.rsp_slot  = hit_idx;
                    st_d.rsp_pa    = (st_q.pa[hit_idx] & ~pmask) | (PA_W'(op_va) & pmask);
                    st_d.rsp_priv  = any_hit && st_q.priv[hit_idx];
                    st_d.rsp_wr    = any_hit && st_q.wr[hit_idx];
                    st_d.rsp_se    = any_hit && st_q.se[hit_idx];
                end
                OP_INSERT:    clr = ovl_vec;
                OP_DMAP_PAGE: clr = hit_vec;
                OP_DMAP_CTX:  clr = ctx_vec;
                OP_DMAP_ALL:  clr = all_vec;
                OP_RD_TAG: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_diag  = tag_w;
                end
                OP_RD_DATA: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_diag  = data_w;
                end
                default: ;
            endcase
        end

        st_d.cnt   = st_q.cnt - CNT_W'($countones(st_q.used & clr));
        st_d.valid = st_q.valid & ~clr;
        st_d.used  = st_q.used & ~clr;

        if (op_valid && op == OP_INSERT) begin
            if (!st_d.used[wslot]) st_d.cnt = st_d.cnt + CNT_W'(1);
            st_d.used[wslot]  = 1'b1;
            st_d.valid[wslot] = 1'b1;
            st_d.va[wslot]    = q_va;
            st_d.pa[wslot]    = ins_pa & ~PA_W'(off_mask64(ins_size));
            st_d.ctx[wslot]   = op_ctx;
            st_d.part[wslot]  = op_part;
            st_d.size[wslot]  = ins_size;
            st_d.rl[wslot]    = op_real;
            st_d.lock[wslot]  = ins_lock;
            st_d.priv[wslot]  = ins_priv;
            st_d.wr[wslot]    = ins_wr;
            st_d.se[wslot]    = ins_se;
            if (!ins_fixed) st_d.ptr = wslot;
        end

        if (op_valid && op == OP_LOOKUP && any_hit && op_upd_used && !st_q.used[hit_idx]) begin
            st_d.used[hit_idx] = 1'b1;
            st_d.cnt           = st_d.cnt + CNT_W'(1);
        end

        // Saturation: keep only the locked slots marked as used
        if (int'(st_d.cnt) == N) begin
            st_d.used = st_d.used & st_d.lock;
            st_d.cnt  = CNT_W'($countones(st_d.used));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ptr <= IDX_W'(N - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_slot  = st_q.rsp_slot;
    assign rsp_pa    = st_q.rsp_pa;
    assign rsp_priv  = st_q.rsp_priv;
    assign rsp_wr    = st_q.rsp_wr;
    assign rsp_se    = st_q.rsp_se;
    assign rsp_diag  = st_q.rsp_diag;

    // R2: at most one slot matches any lookup
    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op == OP_LOOKUP |-> $onehot0(hit_vec));

    // R2: a response follows exactly the lookup and read commands
    a_r2_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_LOOKUP || op == OP_RD_TAG || op == OP_RD_DATA)) |=> rsp_valid);

    // R4: a fixed insert leaves the named slot valid
    a_r4_fixed_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_INSERT && ins_fixed) |=> st_q.valid[$past(op_slot)]);

    // R5: an automatic victim is unlocked whenever an unlocked slot exists
    a_r5_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_INSERT && !ins_fixed && !(&st_q.lock)) |-> !st_q.lock[victim]);

    // R6: the used counter agrees with the used bits
    a_r6_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) == $countones(st_q.used));

    // R9: demap-all keeps every locked valid slot
    a_r9_locked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_DMAP_ALL) |=>
        ((st_q.valid & $past(st_q.valid & st_q.lock)) == $past(st_q.valid & st_q.lock)));
endmodule

// File: tb/tb_ptlb_top.sv
`timescale 1ns/1ps
module tb_ptlb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd7;
    logic [31:0] op_va = '0;
    logic [2:0]  op_part = '0;
    logic [12:0] op_ctx = '0;
    logic        op_real = 1'b0;
    logic        op_upd_used = 1'b0;
    logic [3:0]  op_slot = '0;
    logic        ins_fixed = 1'b0;
    logic [1:0]  ins_size = '0;
    logic [31:0] ins_pa = '0;
    logic        ins_lock = 1'b0, ins_priv = 1'b0, ins_wr = 1'b0, ins_se = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_priv, rsp_wr, rsp_se;
    logic [3:0]  rsp_slot;
    logic [31:0] rsp_pa;
    logic [63:0] rsp_diag;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    ptlb_top dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_va(op_va), .op_part(op_part), .op_ctx(op_ctx), .op_real(op_real),
        .op_upd_used(op_upd_used), .op_slot(op_slot), .ins_fixed(ins_fixed),
        .ins_size(ins_size), .ins_pa(ins_pa), .ins_lock(ins_lock),
        .ins_priv(ins_priv), .ins_wr(ins_wr), .ins_se(ins_se),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_slot(rsp_slot),
        .rsp_pa(rsp_pa), .rsp_priv(rsp_priv), .rsp_wr(rsp_wr), .rsp_se(rsp_se),
        .rsp_diag(rsp_diag)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] va;
        logic [2:0]  part;
        logic [12:0] ctx;
        logic        rl;
        logic [3:0]  slot;
        logic [1:0]  size;
        logic [31:0] pa;
        logic        ehit;
        logic [3:0]  eslot;
        logic [31:0] epa;
    } vec_t;

    // op 1 = fixed insert, op 0 = lookup with expected result
    localparam vec_t VECS [16] = '{
        '{3'd1, 32'h0040_2000, 3'd1, 13'd5, 1'b0, 4'd3, 2'd0, 32'h1234_6000, 1'b0, 4'd0, 32'h0},
        '{3'd0, 32'h0040_2abc, 3'd1, 13'd5, 1'b0, 4'd0, 2'd0, 32'h0,         1'b1, 4'd3, 32'h1234_6abc},
        '{3'd0, 32'h0040_2abc, 3'd1, 13'd6, 1'b0, 4'd0, 2'd0, 32'h0,         1'b0, 4'd0, 32'h0},
        '{3'd0, 32'h0040_2abc, 3'd2, 13'd5, 1'b0, 4'd0, 2'd0, 32'h0,         1'b0, 4'd0, 32'h0},
        '{3'd0, 32'h0040_2abc, 3'd1, 13'd5, 1'b1, 4'd0, 2'd0, 32'h0,         1'b0, 4'd0, 32'h0},
        '{3'd1, 32'h0100_0000, 3'd1, 13'd0, 1'b1, 4'd5, 2'd1, 32'h0800_0000, 1'b0, 4'd0, 32'h0},
        '{3'd0, 32'h0100_fff0, 3'd1, 13'd9, 1'b1, 4'd0, 2'd0, 32'h0,         1'b1, 4'd5, 32'h0800_fff0},
        '{3'd1, 32'h00C1_2345, 3'd2, 13'd1, 1'b0, 4'd7, 2'd3, 32'h4000_0000, 1'b0, 4'd0, 32'h0},
        '{3'd0, 32'h00FF_FFFC, 3'd2, 13'd1, 1'b0, 4'd0, 2'd0, 32'h0,         1'b1, 4'd7, 32'h403F_FFFC},
        '{3'd0, 32'h00BF_FFFC, 3'd2, 13'd1, 1'b0, 4'd0, 2'd0, 32'h0,         1'b0, 4'd0, 32'h0},
        '{3'd1, 32'h00C4_0000, 3'd2, 13'd3, 1'b0, 4'd9, 2'd0, 32'h5000_0000, 1'b0, 4'd0, 32'h0},
        '{3'd0, 32'h00FF_FFFC, 3'd2, 13'd1, 1'b0, 4'd0, 2'd0, 32'h0,         1'b0, 4'd0, 32'h0},
        '{3'd0, 32'h00C4_0010, 3'd2, 13'd3, 1'b0, 4'd0, 2'd0, 32'h0,         1'b1, 4'd9, 32'h5000_0010},
        '{3'd1, 32'h0040_2000, 3'd1, 13'd7, 1'b0, 4'd4, 2'd0, 32'h6000_0000, 1'b0, 4'd0, 32'h0},
        '{3'd0, 32'h0040_2abc, 3'd1, 13'd5, 1'b0, 4'd0, 2'd0, 32'h0,         1'b0, 4'd0, 32'h0},
        '{3'd0, 32'h0040_2abc, 3'd1, 13'd7, 1'b0, 4'd0, 2'd0, 32'h0,         1'b1, 4'd4, 32'h6000_0abc}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [31:0] va, input logic [2:0] part,
                         input logic [12:0] ctx, input logic rl, input logic upd,
                         input logic fixed, input logic [3:0] slot, input logic [1:0] size,
                         input logic [31:0] pa, input logic lock);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_va = va; op_part = part; op_ctx = ctx;
        op_real = rl; op_upd_used = upd; ins_fixed = fixed; op_slot = slot;
        ins_size = size; ins_pa = pa; ins_lock = lock; ins_wr = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd7;
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic [2:0] part,
                        input logic [12:0] ctx, input logic rl, input logic upd,
                        input logic ehit, input logic [3:0] eslot, input logic [31:0] epa);
        issue(3'd0, va, part, ctx, rl, upd, 1'b0, 4'd0, 2'd0, 32'h0, 1'b0);
        if (ehit) chk(req, {27'd0, rsp_hit, rsp_slot, rsp_pa}, {27'd0, 1'b1, eslot, epa});
        else      chk(req, {63'd0, rsp_hit}, 64'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        do_reset();
        // R12: reset state
        chk("R12 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        look("R12 empty table misses", 32'h0, 3'd0, 13'd0, 1'b0, 1'b0, 1'b0, 4'd0, 32'h0);
        chk("R2 rsp_valid after lookup", {63'd0, rsp_valid}, 64'd1);
        issue(3'd5, 32'h0, 3'd0, 13'd0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 32'h0, 1'b0);
        chk("R12 slot 0 tag invalid", rsp_diag, '1);

        // Table walk: R2 matching rules, R3 alignment and overlap, R4 fixed slot
        foreach (VECS[i]) begin
            if (VECS[i].op == 3'd1) begin
                issue(3'd1, VECS[i].va, VECS[i].part, VECS[i].ctx, VECS[i].rl, 1'b0, 1'b1,
                      VECS[i].slot, VECS[i].size, VECS[i].pa, 1'b0);
                chk("R4 no response on insert", {63'd0, rsp_valid}, 64'd0);
            end else begin
                look($sformatf("R2/R3 vector %0d", i), VECS[i].va, VECS[i].part, VECS[i].ctx,
                     VECS[i].rl, 1'b0, VECS[i].ehit, VECS[i].eslot, VECS[i].epa);
            end
        end

        // R10/R11: diagnostic words
        issue(3'd5, 32'h0, 3'd0, 13'd0, 1'b0, 1'b0, 1'b0, 4'd4, 2'd0, 32'h0, 1'b0);
        chk("R10 tag of slot 4", rsp_diag, 64'h2300_0000_0040_2007);
        issue(3'd5, 32'h0, 3'd0, 13'd0, 1'b0, 1'b0, 1'b0, 4'd3, 2'd0, 32'h0, 1'b0);
        chk("R10 tag of overlapped slot 3", rsp_diag, '1);
        issue(3'd6, 32'h0, 3'd0, 13'd0, 1'b0, 1'b0, 1'b0, 4'd4, 2'd0, 32'h0, 1'b0);
        chk("R11 data of slot 4", rsp_diag, 64'h9000_0000_6000_0000);
        issue(3'd1, 32'h0345_6789, 3'd0, 13'd2, 1'b0, 1'b0, 1'b1, 4'd13, 2'd0, 32'h0000_1fff, 1'b0);
        issue(3'd5, 32'h0, 3'd0, 13'd0, 1'b0, 1'b0, 1'b0, 4'd13, 2'd0, 32'h0, 1'b0);
        chk("R3 aligned tag of slot 13", rsp_diag, 64'h0300_0000_0345_6002);

        // R7: demap page
        issue(3'd2, 32'h0040_2000, 3'd1, 13'd7, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 32'h0, 1'b0);
        look("R7 demapped page misses", 32'h0040_2abc, 3'd1, 13'd7, 1'b0, 1'b0, 1'b0, 4'd0, 32'h0);

        // R8: demap context
        issue(3'd1, 32'h1000_0000, 3'd1, 13'd8, 1'b0, 1'b0, 1'b1, 4'd10, 2'd0, 32'h1000_0000, 1'b0);
        issue(3'd1, 32'h2000_0000, 3'd1, 13'd8, 1'b1, 1'b0, 1'b1, 4'd11, 2'd0, 32'h2000_0000, 1'b0);
        issue(3'd1, 32'h1000_0000, 3'd3, 13'd8, 1'b0, 1'b0, 1'b1, 4'd14, 2'd0, 32'h3000_0000, 1'b0);
        issue(3'd3, 32'h0, 3'd1, 13'd8, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 32'h0, 1'b0);
        look("R8 context slot removed", 32'h1000_0004, 3'd1, 13'd8, 1'b0, 1'b0, 1'b0, 4'd0, 32'h0);
        look("R8 real slot kept", 32'h2000_0004, 3'd1, 13'd8, 1'b1, 1'b0, 1'b1, 4'd11, 32'h2000_0004);
        look("R8 other partition kept", 32'h1000_0004, 3'd3, 13'd8, 1'b0, 1'b0, 1'b1, 4'd14, 32'h3000_0004);

        // R9: demap all of partition 2, locked slot survives
        issue(3'd1, 32'h3000_0000, 3'd2, 13'd0, 1'b0, 1'b0, 1'b1, 4'd12, 2'd0, 32'h7000_0000, 1'b1);
        issue(3'd4, 32'h0, 3'd2, 13'd0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 32'h0, 1'b0);
        look("R9 unlocked slot removed", 32'h00C4_0010, 3'd2, 13'd3, 1'b0, 1'b0, 1'b0, 4'd0, 32'h0);
        look("R9 locked slot kept", 32'h3000_0010, 3'd2, 13'd0, 1'b0, 1'b0, 1'b1, 4'd12, 32'h7000_0010);
        look("R9 other partition kept", 32'h0100_0010, 3'd1, 13'd0, 1'b1, 1'b0, 1'b1, 4'd5, 32'h0800_0010);

        // R5/R6: victim order and used-bit saturation
        do_reset();
        issue(3'd1, 32'h6000_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b1, 4'd0, 2'd0, 32'h0, 1'b1);
        issue(3'd1, 32'h6100_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b1, 4'd1, 2'd0, 32'h0, 1'b1);
        issue(3'd1, 32'h7000_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 32'h0, 1'b0);
        issue(3'd1, 32'h7100_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 32'h0, 1'b0);
        look("R5 first auto skips locked", 32'h7000_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b1, 4'd2, 32'h0);
        look("R5 second auto next slot", 32'h7100_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b1, 4'd3, 32'h0);
        for (int k = 4; k < 16; k++) begin
            issue(3'd1, 32'h7200_0000 + (k << 16), 3'd0, 13'd1, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 32'h0, 1'b0);
        end
        look("R5 fill order", 32'h7204_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b1, 4'd4, 32'h0);
        look("R5 wrap reaches last slot", 32'h720F_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b1, 4'd15, 32'h0);
        look("R6 updating lookup marks slot 2", 32'h7000_0000, 3'd0, 13'd1, 1'b0, 1'b1, 1'b1, 4'd2, 32'h0);
        issue(3'd1, 32'h7300_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 32'h0, 1'b0);
        look("R6 after saturation victim skips used slot", 32'h7300_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b1, 4'd3, 32'h0);
        look("R6 evicted slot 3 entry gone", 32'h7100_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b0, 4'd0, 32'h0);
        look("R6 used slot 2 kept", 32'h7000_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b1, 4'd2, 32'h0);

        // R5: all slots locked falls back to slot N-1
        do_reset();
        for (int k = 0; k < 16; k++) begin
            issue(3'd1, 32'h4000_0000 + (k << 16), 3'd0, 13'd1, 1'b0, 1'b0, 1'b1, 4'(k), 2'd0, 32'h0, 1'b1);
        end
        issue(3'd1, 32'h5000_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 32'h0, 1'b0);
        look("R5 all locked uses last slot", 32'h5000_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b1, 4'd15, 32'h0);
        look("R5 last slot old entry gone", 32'h400F_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b0, 4'd0, 32'h0);
        look("R5 other locked slot intact", 32'h400E_0000, 3'd0, 13'd1, 1'b0, 1'b0, 1'b1, 4'd14, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule